// File: doc/BRIEF.md
# Packed SIMD Complex Multiply Unit

This block is a three-stage pipelined multiplier for 128-bit packed vectors. Each operation supplies two operands and a 3-bit mode. The mode selects one of four jobs on the same datapath: four independent 32-bit integer multiplies, 16-bit complex multiplies in Q15 (with or without rounding), a rounded multiply of one operand by the conjugate of the other, or sixteen byte-wide GF(2^8) multiplies.

A new operation can be accepted on every clock. Each result appears, with its own valid strobe, exactly three clocks after its operation was accepted, whatever the mode. The GF(2^8) lanes reduce by a reducing polynomial held in an internal 8-bit register. The x^8 term of the polynomial is implicit. The register can be rewritten through a write strobe.

Top module: `simd_cmul_unit`

## Requirements
- R1: Mode 0 splits each operand into four 32-bit words (word k is bits [32k+31:32k]). Result word k is the low 32 bits of op_a word k times op_b word k.
- R2: Mode 1 reads each 32-bit word as a complex value, real part in bits [31:16] and imaginary part in bits [15:0], both signed. Result real = (ar·br − ai·bi) and imaginary = (ar·bi + ai·br), each shifted right arithmetically by 15 without rounding and then saturated. The result uses the same layout.
- R3: Mode 2 is mode 1 with 2^14 added to each sum before the shift by 15.
- R4: Mode 3 is the rounded product of op_a by the conjugate of op_b: real = ar·br + ai·bi, imaginary = ai·br − ar·bi, with the rounding and shift of R3.
- R5: Mode 4 multiplies every byte of op_a by the byte of op_b in the same position in GF(2^8). The reducing polynomial's low 8 bits come from a register that reset loads with 0x1D.
- R6: When poly_we is high on a clock edge, poly_val is loaded into the polynomial register. Operations accepted on later edges use the new value. An operation accepted on the same edge uses the old value.
- R7: Every complex result part saturates to the range 0x8000..0x7FFF. For example, (−1+−1j)·(−1+−1j) in mode 1 gives an imaginary part of 0x7FFF.
- R8: out_valid is high exactly three clocks after an edge at which in_valid was high, and low otherwise. Back-to-back operations produce back-to-back results.
- R9: Mode codes 5, 6 and 7 produce a valid result of all zeros.
- R10: out_data is zero whenever out_valid is low, including during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted on this edge |
| mode | input | 3 | Operation select (0..4, others give zero) |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| poly_we | input | 1 | Load the GF polynomial register |
| poly_val | input | 8 | New polynomial, low 8 bits |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Result vector |

## Verification
Random operand vectors in every mode are mixed with gaps in in_valid. This separates the latency pipeline from the data path and shows that modes do not leak into each other. Complex operands are drawn largely from the extremes 0x8000 and 0x7FFF, together with directed values whose sum is exactly 2^14. These tell truncation from rounding and expose any missing saturation. GF products are checked before and after a polynomial rewrite, which separates a hard-wired polynomial from the register. Codes 5 to 7 confirm that undefined modes yield zero.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = 8;
    localparam int ACC_W  = 2 * HALF_W + 2;

    typedef enum logic [2:0] {
        MD_MUL32    = 3'd0,
        MD_CPLX     = 3'd1,
        MD_CPLX_RND = 3'd2,
        MD_CONJ_RND = 3'd3,
        MD_GF8      = 3'd4
    } mul_mode_e;

    // Narrow a complex sum to Q15 with optional rounding and saturation.
    function automatic logic [HALF_W-1:0] q15_narrow(input logic signed [ACC_W-1:0] acc,
                                                     input logic rnd);
        logic signed [ACC_W-1:0] biased;
        logic signed [ACC_W-1:0] shifted;
        biased  = rnd ? acc + ACC_W'(16384) : acc;
        shifted = biased >>> 15;
        if (shifted > ACC_W'(32767))
            return 16'h7FFF;
        else if (shifted < -ACC_W'(32768))
            return 16'h8000;
        else
            return shifted[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/gf_byte_mul.sv
module gf_byte_mul
    import simd_mul_pkg::*;
(
    input  logic [BYTE_W-1:0] x,
    input  logic [BYTE_W-1:0] y,
    input  logic [BYTE_W-1:0] poly,
    output logic [BYTE_W-1:0] p
);
    // Shift-and-add with reduction after every doubling.
    always_comb begin
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] mult;
        acc  = '0;
        mult = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i])
                acc = acc ^ mult;
            mult = mult[BYTE_W-1] ? ((mult << 1) ^ poly) : (mult << 1);
        end
        p = acc;
    end
endmodule

// File: rtl/simd_word_mul.sv
module simd_word_mul
    import simd_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W-1:0] b_w,
    input  logic [BYTE_W-1:0] poly,
    input  logic [2:0]        mode_s2,
    input  logic              v_s2,
    output logic [WORD_W-1:0] res_o
);
    localparam int NUM_BYTES = WORD_W / BYTE_W;

    logic signed [HALF_W-1:0] ar, ai, br, bi;
    logic signed [WORD_W-1:0] pr_rr, pr_ii, pr_ri, pr_ir;
    logic        [WORD_W-1:0] pr_lo;
    logic        [WORD_W-1:0] gf_w;

    assign ar = a_w[WORD_W-1:HALF_W];
    assign ai = a_w[HALF_W-1:0];
    assign br = b_w[WORD_W-1:HALF_W];
    assign bi = b_w[HALF_W-1:0];

    assign pr_rr = WORD_W'(ar) * WORD_W'(br);
    assign pr_ii = WORD_W'(ai) * WORD_W'(bi);
    assign pr_ri = WORD_W'(ar) * WORD_W'(bi);
    assign pr_ir = WORD_W'(ai) * WORD_W'(br);
    assign pr_lo = a_w * b_w;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_gf
        gf_byte_mul u_gf (
            .x   (a_w[g*BYTE_W +: BYTE_W]),
            .y   (b_w[g*BYTE_W +: BYTE_W]),
            .poly(poly),
            .p   (gf_w[g*BYTE_W +: BYTE_W])
        );
    end

    // Stage 2: partial products and byte products.
    logic signed [WORD_W-1:0] s2_rr, s2_ii, s2_ri, s2_ir;
    logic        [WORD_W-1:0] s2_lo, s2_gf;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_rr <= '0;
            s2_ii <= '0;
            s2_ri <= '0;
            s2_ir <= '0;
            s2_lo <= '0;
            s2_gf <= '0;
        end else begin
            s2_rr <= pr_rr;
            s2_ii <= pr_ii;
            s2_ri <= pr_ri;
            s2_ir <= pr_ir;
            s2_lo <= pr_lo;
            s2_gf <= gf_w;
        end
    end

    // Stage 3: combine, round, saturate, select.
    logic signed [ACC_W-1:0] rr_x, ii_x, ri_x, ir_x;
    logic signed [ACC_W-1:0] re_sum, im_sum;
    logic        [WORD_W-1:0] res_nxt;
    mul_mode_e                md;

    assign rr_x = ACC_W'(s2_rr);
    assign ii_x = ACC_W'(s2_ii);
    assign ri_x = ACC_W'(s2_ri);
    assign ir_x = ACC_W'(s2_ir);
    assign md   = mul_mode_e'(mode_s2);

    always_comb begin
        if (md == MD_CONJ_RND) begin
            re_sum = rr_x + ii_x;
            im_sum = ir_x - ri_x;
        end else begin
            re_sum = rr_x - ii_x;
            im_sum = ri_x + ir_x;
        end
    end

    always_comb begin
        res_nxt = '0;
        if (v_s2) begin
            case (md)
                MD_MUL32:    res_nxt = s2_lo;
                MD_CPLX:     res_nxt = {q15_narrow(re_sum, 1'b0), q15_narrow(im_sum, 1'b0)};
                MD_CPLX_RND,
                MD_CONJ_RND: res_nxt = {q15_narrow(re_sum, 1'b1), q15_narrow(im_sum, 1'b1)};
                MD_GF8:      res_nxt = s2_gf;
                default:     res_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_o <= '0;
        else
            res_o <= res_nxt;
    end
endmodule

// File: rtl/simd_cmul_unit.sv
module simd_cmul_unit
    import simd_mul_pkg::*;
#(
    parameter int          NUM_WORDS  = 4,
    parameter logic [7:0]  POLY_RESET = 8'h1D,
    localparam int         VEC_W      = NUM_WORDS * WORD_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       mode,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic             poly_we,
    input  logic [7:0]       poly_val,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    logic [BYTE_W-1:0] poly_q;
    logic [VEC_W-1:0]  a_s1, b_s1;
    logic [BYTE_W-1:0] poly_s1;
    logic [2:0]        mode_s1, mode_s2;
    logic              v_s1, v_s2;

    always_ff @(posedge clk) begin
        if (rst)
            poly_q <= POLY_RESET;
        else if (poly_we)
            poly_q <= poly_val;
    end

    // Stage 1: capture operation and current polynomial.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_s1    <= '0;
            b_s1    <= '0;
            poly_s1 <= POLY_RESET;
            mode_s1 <= '0;
            v_s1    <= 1'b0;
        end else begin
            a_s1    <= op_a;
            b_s1    <= op_b;
            poly_s1 <= poly_q;
            mode_s1 <= mode;
            v_s1    <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_s2   <= '0;
            v_s2      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            mode_s2   <= mode_s1;
            v_s2      <= v_s1;
            out_valid <= v_s2;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        simd_word_mul u_word (
            .clk    (clk),
            .rst    (rst),
            .a_w    (a_s1[w*WORD_W +: WORD_W]),
            .b_w    (b_s1[w*WORD_W +: WORD_W]),
            .poly   (poly_s1),
            .mode_s2(mode_s2),
            .v_s2   (v_s2),
            .res_o  (out_data[w*WORD_W +: WORD_W])
        );
    end

    // R8: accepted operation reaches stage 1, stage 2 drives the output strobe
    a_r8_accept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v_s1);
    a_r8_to_out: assert property (@(posedge clk) disable iff (rst)
        v_s2 |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !v_s2 |=> !out_valid);
    // R9: undefined modes leave a zero valid result
    a_r9_bad_mode_zero: assert property (@(posedge clk) disable iff (rst)
        (v_s2 && mode_s2 > 3'd4) |=> (out_valid && out_data == '0));
    // R10: idle output is zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_data == '0);
    // R5: polynomial register starts at its reset value
    a_r5_poly_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> poly_q == POLY_RESET);
endmodule

// File: tb/test_simd_cmul_unit.sv
module test_simd_cmul_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   mode;
    logic [127:0] op_a, op_b;
    logic         poly_we;
    logic [7:0]   poly_val;
    logic         out_valid;
    logic [127:0] out_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [7:0] tb_poly = 8'h1D;

    logic [127:0] exp_d [8];
    logic         exp_v [8];
    string        exp_t [8];

    always #10 clk = ~clk;

    simd_cmul_unit i_simd_cmul_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .poly_we(poly_we), .poly_val(poly_val),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] ref_sat(longint v, bit rnd);
        longint t;
        t = rnd ? v + 16384 : v;
        t = t >>> 15;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t[15:0];
    endfunction

    function automatic logic [7:0] ref_gf(logic [7:0] x, logic [7:0] y, logic [7:0] pl);
        logic [14:0] cl;
        logic [8:0]  full;
        cl = '0;
        full = {1'b1, pl};
        for (int i = 0; i < 8; i++)
            if (y[i]) cl = cl ^ (15'(x) << i);
        for (int k = 14; k >= 8; k--)
            if (cl[k]) cl = cl ^ (15'(full) << (k - 8));
        return cl[7:0];
    endfunction

    function automatic logic [127:0] ref_op(logic [2:0] m, logic [127:0] a, logic [127:0] b,
                                            logic [7:0] pl);
        logic [127:0] r;
        r = '0;
        for (int w = 0; w < 4; w++) begin
            logic [31:0] aw, bw;
            longint ar, ai, br, bi, re, im;
            logic [63:0] full;
            aw = a[w*32 +: 32];
            bw = b[w*32 +: 32];
            ar = longint'($signed(aw[31:16]));
            ai = longint'($signed(aw[15:0]));
            br = longint'($signed(bw[31:16]));
            bi = longint'($signed(bw[15:0]));
            full = 64'(aw) * 64'(bw);
            case (m)
                3'd0: r[w*32 +: 32] = full[31:0];
                3'd1: r[w*32 +: 32] = {ref_sat(ar*br - ai*bi, 1'b0), ref_sat(ar*bi + ai*br, 1'b0)};
                3'd2: r[w*32 +: 32] = {ref_sat(ar*br - ai*bi, 1'b1), ref_sat(ar*bi + ai*br, 1'b1)};
                3'd3: begin
                    re = ar*br + ai*bi;
                    im = ai*br - ar*bi;
                    r[w*32 +: 32] = {ref_sat(re, 1'b1), ref_sat(im, 1'b1)};
                end
                3'd4: for (int k = 0; k < 4; k++)
                    r[w*32 + k*8 +: 8] = ref_gf(aw[k*8 +: 8], bw[k*8 +: 8], pl);
                default: r[w*32 +: 32] = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R9";
        endcase
    endfunction

    // One cycle: check result of op issued three steps ago (R8 timing), then drive new op.
    task automatic step(input bit v, input logic [2:0] m, input logic [127:0] a,
                        input logic [127:0] b, input bit pw, input logic [7:0] pv,
                        input string tag);
        int ci;
        int wi;
        @(negedge clk);
        ci = (cyc + 5) % 8;
        total++;
        if (out_valid !== exp_v[ci] || out_data !== exp_d[ci]) begin
            bad++;
            $display("FAIL %s R8: valid=%0b data=%h expected valid=%0b data=%h",
                     exp_t[ci], out_valid, out_data, exp_v[ci], exp_d[ci]);
        end
        wi = cyc % 8;
        in_valid = v;
        mode     = m;
        op_a     = a;
        op_b     = b;
        poly_we  = pw;
        poly_val = pv;
        exp_v[wi] = v;
        exp_d[wi] = v ? ref_op(m, a, b, tb_poly) : 128'h0;
        exp_t[wi] = v ? tag : "R10";
        if (pw) tb_poly = pv;
        cyc++;
    endtask

    task automatic idle();
        step(1'b0, 3'd0, '0, '0, 1'b0, 8'h00, "R10");
    endtask

    function automatic logic [15:0] pick_half();
        case ($urandom_range(0, 3))
            0: return 16'h8000;
            1: return 16'h7FFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [127:0] rnd_vec(bit extremes);
        logic [127:0] r;
        for (int h = 0; h < 8; h++)
            r[h*16 +: 16] = extremes ? pick_half() : 16'($urandom);
        return r;
    endfunction

    initial begin
        for (int c = 0; c < 50000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R8: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; mode = '0; op_a = '0; op_b = '0;
        poly_we = 1'b0; poly_val = '0;
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R10";
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            bad++;
            $display("FAIL R10 reset: valid=%0b data=%h expected 0/0", out_valid, out_data);
        end
        rst = 1'b0;

        // R1 directed: all-ones squared, sign-bit times two
        step(1, 3'd0, {32'hFFFFFFFF, 32'h80000000, 32'h0001_0000, 32'h12345678},
                      {32'hFFFFFFFF, 32'h00000002, 32'h0001_0000, 32'h00000003}, 0, 0, "R1");
        // R7 saturation: (-1-1j)^2 in Q15 and its conjugate product
        step(1, 3'd1, {4{32'h80008000}}, {4{32'h80008000}}, 0, 0, "R7");
        step(1, 3'd3, {4{32'h80008000}}, {4{32'h80008000}}, 0, 0, "R7");
        // R2/R3 rounding boundary: sum of exactly 2^14
        step(1, 3'd1, {4{32'h4000_0000}}, {4{32'h0001_0001}}, 0, 0, "R2");
        step(1, 3'd2, {4{32'h4000_0000}}, {4{32'h0001_0001}}, 0, 0, "R3");
        step(1, 3'd2, {4{32'hC000_0000}}, {4{32'h0001_0001}}, 0, 0, "R3");
        // R4 conjugate directed
        step(1, 3'd3, {4{32'h2000_4000}}, {4{32'h4000_2000}}, 0, 0, "R4");
        // R5 GF with reset polynomial: 0x02*0x80 -> 0x1D
        step(1, 3'd4, {16{8'h02}}, {16{8'h80}}, 0, 0, "R5");
        // R9 undefined modes
        step(1, 3'd5, {4{32'hFFFFFFFF}}, {4{32'h7FFF7FFF}}, 0, 0, "R9");
        step(1, 3'd6, {4{32'h12345678}}, {4{32'h12345678}}, 0, 0, "R9");
        step(1, 3'd7, {4{32'h80008000}}, {4{32'h80008000}}, 0, 0, "R9");
        // R6: op in the write cycle uses old poly, next op the new one
        step(1, 3'd4, {16{8'h02}}, {16{8'h80}}, 1, 8'h1B, "R6");
        step(1, 3'd4, {16{8'h02}}, {16{8'h80}}, 0, 0, "R6");
        step(1, 3'd4, {16{8'h57}}, {16{8'h83}}, 0, 0, "R6");
        repeat (3) idle();

        // Random mix with gaps; occasional poly rewrite
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            bit v, pw;
            m  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) < 6) m = 3'($urandom_range(0, 4));
            v  = ($urandom_range(0, 4) != 0);
            pw = ($urandom_range(0, 30) == 0);
            step(v, m, rnd_vec(m inside {3'd1, 3'd2, 3'd3}), rnd_vec(m inside {3'd1, 3'd2, 3'd3}),
                 pw, 8'($urandom), v ? mode_tag(m) : "R10");
        end
        repeat (4) idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule